// File: doc/BRIEF.md
# Clock source select controller

This block picks the system clock from three running sources: the locked-loop output, the internal reference and the external reference. A two-bit select input, held in a register in the monitor domain, names the wanted source. The output moves to a new source only after that source has shown three rising edges. If the new source stays silent, the output keeps the clock it already has. A status output reports which source has been committed.

The block also drives enables for the locked loop and the external oscillator, following the low-power bit and the reference-select bit. It produces two gated reference clocks for peripherals, each with its own enable and its own stop-mode enable. Its last stage is a bus clock divider that follows the divide field immediately. A free-running monitor clock, synchronous to the select and control inputs, runs the switch controller.

Top module: `clk_src_sel`

## Requirements
- R1: Select code 2'b00 picks the locked-loop clock, 2'b01 the internal reference and 2'b10 the external reference. Once switching completes, `clk_out` runs at the rate of the picked source and `active_sel_o` shows the same code.
- R2: Select code 2'b11 is reserved. Writing it leaves both the pending selection and the committed selection unchanged.
- R3: The committed selection changes only after three rising edges of the new source have been seen. Two monitor cycles after a new code is written, `active_sel_o` still shows the old code.
- R4: If the new source shows no edge within 64 monitor cycles, the switch is abandoned. `active_sel_o` and `clk_out` stay on the old source, and no new attempt is made until a different code is written.
- R5: `clk_out` is free of glitches. No high or low phase is shorter than the shortest half-period of the three sources, and at most one source is gated through at any time.
- R6: `loop_en_o` is low when the select code is not 2'b00 and `low_pwr_i` is 1. With `low_pwr_i` at 0, or with code 2'b00, it is high outside stop mode.
- R7: With select 2'b10, `ref_int_i` at 0 and `low_pwr_i` at 1, the external reference drives `clk_out`, `loop_en_o` is low and `ext_osc_en_o` is high.
- R8: While `stop_i` is 1, `clk_out` and `bus_clk_o` are static and `loop_en_o` is low.
- R9: `int_ref_clk_o` follows the internal reference when `int_en_i` is 1 and either `stop_i` is 0 or `int_stop_en_i` is 1. Otherwise it is held low.
- R10: `ext_ref_clk_o` follows the external reference when `ext_en_i` is 1 and either `stop_i` is 0 or `ext_stop_en_i` is 1. Otherwise it is held low.
- R11: Divide field 2'b00, 2'b01, 2'b10 and 2'b11 gives `bus_clk_o` equal to `clk_out` divided by 1, 2, 4 and 8. A new field value applies at once, without the switch handshake.
- R12: After reset the committed selection is 2'b00. `clk_out` then runs from the locked-loop clock once its gate has been opened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mon | input | 1 | Free-running monitor clock for the switch controller |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_fll | input | 1 | Locked-loop output clock |
| clk_int | input | 1 | Internal reference clock |
| clk_ext | input | 1 | External reference clock |
| sel_i | input | 2 | Source select code |
| ref_int_i | input | 1 | Loop reference select, 1 = internal |
| low_pwr_i | input | 1 | Turn the loop off while it is bypassed |
| stop_i | input | 1 | Stop mode request |
| int_en_i | input | 1 | Internal reference output enable |
| int_stop_en_i | input | 1 | Keep internal reference output running in stop |
| ext_en_i | input | 1 | External reference output enable |
| ext_stop_en_i | input | 1 | Keep external reference output running in stop |
| bdiv_i | input | 2 | Bus divide field |
| clk_out | output | 1 | Selected system clock |
| bus_clk_o | output | 1 | Divided bus clock |
| int_ref_clk_o | output | 1 | Gated internal reference clock |
| ext_ref_clk_o | output | 1 | Gated external reference clock |
| loop_en_o | output | 1 | Locked loop enable |
| ext_osc_en_o | output | 1 | External oscillator enable |
| active_sel_o | output | 2 | Committed source code |

## Verification
Several properties are checked on every monitor cycle: at most one source gate is open, the committed code never takes the reserved value and changes only at the end of a pending switch, an abandoned switch leaves the commitment unchanged, a reserved write holds the select register, and the stop and external-low-power enables behave as required. Other behaviour can only be shown by the bench scenarios, which count clock edges over fixed windows. These scenarios cover output rates per source and divide setting, the three-edge delay, the silent-source fallback, the reference gating in stop mode and the pulse widths of `clk_out` during switches.

// File: rtl/clk_src_sel.sv
`timescale 1ns/1ps
module clk_src_sel #(
  parameter int EDGES = 3,
  parameter int LIMIT = 64
) (
  input  logic       clk_mon,
  input  logic       rst_n,
  input  logic       clk_fll,
  input  logic       clk_int,
  input  logic       clk_ext,
  input  logic [1:0] sel_i,
  input  logic       ref_int_i,
  input  logic       low_pwr_i,
  input  logic       stop_i,
  input  logic       int_en_i,
  input  logic       int_stop_en_i,
  input  logic       ext_en_i,
  input  logic       ext_stop_en_i,
  input  logic [1:0] bdiv_i,
  output logic       clk_out,
  output logic       bus_clk_o,
  output logic       int_ref_clk_o,
  output logic       ext_ref_clk_o,
  output logic       loop_en_o,
  output logic       ext_osc_en_o,
  output logic [1:0] active_sel_o
);
  localparam int IW = $clog2(LIMIT + 1);
  localparam int EW = $clog2(EDGES + 1);

  logic [2:0] clks, gate, tog, ts1, ts2, ts3, edge_v;
  logic [1:0] sel_q, tgt, cand;
  logic       pend, drop, edge_c;
  logic [EW-1:0] ecnt;
  logic [IW-1:0] idle;
  logic [2:0] dcnt;
  logic       ig, eg;

  assign clks = {clk_ext, clk_int, clk_fll};

  // per-source handshake: sync want into own domain, gate on falling edge
  for (genvar i = 0; i < 3; i++) begin : g_src
    logic s1, s2, gq, tq, want;
    assign want = (tgt == 2'(i)) & ~stop_i & ~|(gate & ~(3'b001 << i));
    always_ff @(posedge clks[i] or negedge rst_n)
      if (!rst_n) begin
        s1 <= 1'b0; s2 <= 1'b0; tq <= 1'b0;
      end else begin
        s1 <= want; s2 <= s1; tq <= ~tq;
      end
    always_ff @(negedge clks[i] or negedge rst_n)
      if (!rst_n) gq <= 1'b0;
      else        gq <= s2;
    assign gate[i] = gq;
    assign tog[i]  = tq;
  end

  always_ff @(posedge clk_mon or negedge rst_n)
    if (!rst_n) begin
      ts1 <= '0; ts2 <= '0; ts3 <= '0;
    end else begin
      ts1 <= tog; ts2 <= ts1; ts3 <= ts2;
    end

  assign edge_v = ts2 ^ ts3;
  assign edge_c = edge_v[cand];

  always_ff @(posedge clk_mon or negedge rst_n)
    if (!rst_n) begin
      sel_q <= 2'b00; tgt <= 2'b00; cand <= 2'b00;
      pend <= 1'b0; drop <= 1'b0; ecnt <= '0; idle <= '0;
    end else begin
      if (sel_i != 2'b11) sel_q <= sel_i;
      if (!pend) begin
        if (sel_q != tgt && !drop) begin
          pend <= 1'b1; cand <= sel_q; ecnt <= '0; idle <= '0;
        end
      end else if (sel_q != cand) begin
        pend <= 1'b0;
      end else if (edge_c) begin
        idle <= '0;
        if (ecnt == EW'(EDGES - 1)) begin
          tgt <= cand; pend <= 1'b0;
        end else begin
          ecnt <= ecnt + 1'b1;
        end
      end else if (idle == IW'(LIMIT - 1)) begin
        pend <= 1'b0; drop <= 1'b1;
      end else begin
        idle <= idle + 1'b1;
      end
      if (sel_i != 2'b11 && sel_i != sel_q) drop <= 1'b0;
    end

  assign active_sel_o = tgt;
  assign clk_out      = |(clks & gate);

  always_ff @(posedge clk_out or negedge rst_n)
    if (!rst_n) dcnt <= '0;
    else        dcnt <= dcnt + 1'b1;

  assign bus_clk_o = (bdiv_i == 2'b00) ? clk_out : dcnt[bdiv_i - 2'd1];

  always_ff @(negedge clk_int or negedge rst_n)
    if (!rst_n) ig <= 1'b0;
    else        ig <= int_en_i & (~stop_i | int_stop_en_i);

  always_ff @(negedge clk_ext or negedge rst_n)
    if (!rst_n) eg <= 1'b0;
    else        eg <= ext_en_i & (~stop_i | ext_stop_en_i);

  assign int_ref_clk_o = clk_int & ig;
  assign ext_ref_clk_o = clk_ext & eg;

  assign loop_en_o    = ~stop_i & ~(low_pwr_i & (sel_q != 2'b00));
  assign ext_osc_en_o = stop_i ? (ext_en_i & ext_stop_en_i)
                               : (ext_en_i | ~ref_int_i | (sel_q == 2'b10));

  assert_one_gate_R5: assert property (@(posedge clk_mon) disable iff (!rst_n)
    $onehot0(gate));

  assert_legal_commit_R1: assert property (@(posedge clk_mon) disable iff (!rst_n)
    tgt != 2'b11);

  assert_switch_after_proof_R3: assert property (@(posedge clk_mon) disable iff (!rst_n)
    !$stable(tgt) |-> $past(pend) && $past(edge_c));

  assert_abandon_keeps_R4: assert property (@(posedge clk_mon) disable iff (!rst_n)
    (pend && !edge_c && sel_q == cand && idle == IW'(LIMIT - 1)) |=> $stable(tgt) && !pend);

  assert_reserved_hold_R2: assert property (@(posedge clk_mon) disable iff (!rst_n)
    sel_i == 2'b11 |=> $stable(sel_q));

  assert_bypass_ext_R7: assert property (@(posedge clk_mon) disable iff (!rst_n)
    (sel_q == 2'b10 && !stop_i && low_pwr_i) |-> ext_osc_en_o && !loop_en_o);

  assert_stop_loop_off_R8: assert property (@(posedge clk_mon) disable iff (!rst_n)
    stop_i |-> !loop_en_o);
endmodule

// File: tb/tb_clk_src_sel.sv
`timescale 1ns/1ps
module tb_clk_src_sel;
  logic clk_mon = 0, rst_n = 0;
  logic clk_fll = 0, clk_int = 0, clk_ext = 0;
  bit   run_fll = 1, run_int = 1, run_ext = 1;
  logic [1:0] sel_i = 0, bdiv_i = 0;
  logic ref_int_i = 1, low_pwr_i = 0, stop_i = 0;
  logic int_en_i = 0, int_stop_en_i = 0, ext_en_i = 0, ext_stop_en_i = 0;
  logic clk_out, bus_clk_o, int_ref_clk_o, ext_ref_clk_o, loop_en_o, ext_osc_en_o;
  logic [1:0] active_sel_o;

  int checks = 0, fails = 0, glitches = 0;
  int n_out = 0, n_bus = 0, n_iref = 0, n_eref = 0;
  realtime t_last = 0;
  bit done = 0;

  always #2.5 clk_mon = ~clk_mon;
  always #10  if (run_fll) clk_fll = ~clk_fll;
  always #16  if (run_int) clk_int = ~clk_int;
  always #20  if (run_ext) clk_ext = ~clk_ext;

  clk_src_sel dut (
    .clk_mon(clk_mon), .rst_n(rst_n), .clk_fll(clk_fll), .clk_int(clk_int),
    .clk_ext(clk_ext), .sel_i(sel_i), .ref_int_i(ref_int_i), .low_pwr_i(low_pwr_i),
    .stop_i(stop_i), .int_en_i(int_en_i), .int_stop_en_i(int_stop_en_i),
    .ext_en_i(ext_en_i), .ext_stop_en_i(ext_stop_en_i), .bdiv_i(bdiv_i),
    .clk_out(clk_out), .bus_clk_o(bus_clk_o), .int_ref_clk_o(int_ref_clk_o),
    .ext_ref_clk_o(ext_ref_clk_o), .loop_en_o(loop_en_o), .ext_osc_en_o(ext_osc_en_o),
    .active_sel_o(active_sel_o));

  always @(posedge clk_out)       n_out++;
  always @(posedge bus_clk_o)     n_bus++;
  always @(posedge int_ref_clk_o) n_iref++;
  always @(posedge ext_ref_clk_o) n_eref++;

  // R5: no phase of clk_out shorter than the 10 ns half-period of the fastest source
  always @(clk_out) begin
    if (rst_n && t_last > 0 && ($realtime - t_last) < 9.9) glitches++;
    t_last = $realtime;
  end

  function automatic int rate(input int s);
    return (s == 0) ? 48 : (s == 1) ? 30 : 24;
  endfunction

  function automatic bit near(input int a, input int e);
    return (a - e <= 1) && (e - a <= 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_win(output int no, output int nb);
    int o0, b0;
    o0 = n_out; b0 = n_bus;
    #960;
    no = n_out - o0; nb = n_bus - b0;
  endtask

  task automatic set_sel(input logic [1:0] s);
    @(negedge clk_mon); sel_i = s;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run();
    end
  end

  initial begin
    int no, nb, i0, e0, exp_sel;
    int unsigned seed;
    logic [1:0] s;
    bit lp;
    seed = $urandom(32'd2024);

    #52 rst_n = 1;
    @(negedge clk_mon);
    chk(active_sel_o == 2'b00, "R12 reset selection", active_sel_o, 0);
    chk(loop_en_o == 1'b1, "R6 loop on after reset", loop_en_o, 1);
    #600;
    count_win(no, nb);
    chk(near(no, 48), "R12 loop clock after reset", no, 48);

    // R3: commitment waits for edges of the new source
    set_sel(2'b01);
    @(negedge clk_mon); @(negedge clk_mon);
    chk(active_sel_o == 2'b00, "R3 no early switch", active_sel_o, 0);
    #700;
    chk(active_sel_o == 2'b01, "R1 internal committed", active_sel_o, 1);
    count_win(no, nb);
    chk(near(no, 30), "R1 internal rate", no, 30);

    // R2: reserved code changes nothing
    set_sel(2'b11);
    #700;
    chk(active_sel_o == 2'b01, "R2 reserved holds", active_sel_o, 1);
    count_win(no, nb);
    chk(near(no, 30), "R2 reserved rate", no, 30);

    // R7: bypassed external low-power
    ref_int_i = 0; low_pwr_i = 1;
    set_sel(2'b10);
    #700;
    chk(active_sel_o == 2'b10, "R7 external committed", active_sel_o, 2);
    chk(loop_en_o == 1'b0, "R7 loop off", loop_en_o, 0);
    chk(ext_osc_en_o == 1'b1, "R7 oscillator on", ext_osc_en_o, 1);
    count_win(no, nb);
    chk(near(no, 24), "R7 external rate", no, 24);
    low_pwr_i = 0;
    @(negedge clk_mon);
    chk(loop_en_o == 1'b1, "R6 loop kept on in bypass", loop_en_o, 1);
    ref_int_i = 1;

    // R11: divider
    for (int d = 0; d < 4; d++) begin
      @(negedge clk_mon); bdiv_i = 2'(d);
      count_win(no, nb);
      chk(near(nb, no >> d), "R11 bus divide", nb, no >> d);
    end
    bdiv_i = 2'b00;

    // random selections, all sources running
    exp_sel = 2;
    for (int k = 0; k < 12; k++) begin
      s  = 2'($urandom_range(0, 3));
      lp = 1'($urandom_range(0, 1));
      low_pwr_i = lp;
      set_sel(s);
      if (s != 2'b11) exp_sel = s;
      #700;
      chk(active_sel_o == 2'(exp_sel), "R1 random selection", active_sel_o, exp_sel);
      chk(loop_en_o == !(lp && exp_sel != 0), "R6 random loop enable", loop_en_o,
          !(lp && exp_sel != 0));
      count_win(no, nb);
      chk(near(no, rate(exp_sel)), "R1 random rate", no, rate(exp_sel));
    end
    low_pwr_i = 0;

    // R4: silent source is abandoned
    set_sel(2'b10);
    #700;
    run_int = 0;
    set_sel(2'b01);
    #900;
    chk(active_sel_o == 2'b10, "R4 silent source kept old", active_sel_o, 2);
    count_win(no, nb);
    chk(near(no, 24), "R4 old clock still running", no, 24);
    run_int = 1;
    #700;
    chk(active_sel_o == 2'b10, "R4 no retry after abandon", active_sel_o, 2);
    set_sel(2'b00);
    #700;
    set_sel(2'b01);
    #700;
    chk(active_sel_o == 2'b01, "R4 new write retries", active_sel_o, 1);

    // R8-R10: stop mode
    int_en_i = 1; ext_en_i = 1; int_stop_en_i = 1; ext_stop_en_i = 0;
    #200;
    i0 = n_iref; e0 = n_eref;
    #960;
    chk(near(n_iref - i0, 30), "R9 internal ref runs", n_iref - i0, 30);
    chk(near(n_eref - e0, 24), "R10 external ref runs", n_eref - e0, 24);
    @(negedge clk_mon); stop_i = 1;
    #300;
    chk(loop_en_o == 1'b0, "R8 loop off in stop", loop_en_o, 0);
    i0 = n_iref; e0 = n_eref;
    count_win(no, nb);
    chk(no == 0, "R8 clk_out static", no, 0);
    chk(nb == 0, "R8 bus clock static", nb, 0);
    chk(near(n_iref - i0, 30), "R9 internal ref kept in stop", n_iref - i0, 30);
    chk(n_eref - e0 == 0, "R10 external ref static in stop", n_eref - e0, 0);
    int_stop_en_i = 0; ext_stop_en_i = 1;
    #200;
    i0 = n_iref; e0 = n_eref;
    #960;
    chk(n_iref - i0 == 0, "R9 internal ref static in stop", n_iref - i0, 0);
    chk(near(n_eref - e0, 24), "R10 external ref kept in stop", n_eref - e0, 24);
    @(negedge clk_mon); stop_i = 0;
    #700;
    count_win(no, nb);
    chk(near(no, 30), "R8 clock resumes after stop", no, 30);

    chk(glitches == 0, "R5 no short phase on clk_out", glitches, 0);
    done = 1;
    finish_run();
  end
endmodule